// File: doc/BRIEF.md
# Supervisory Reset with Watchdog

This block watches over a processor and holds it in reset whenever something is wrong. It has three inputs. The first is a supply-good flag, already synchronous, from an external voltage comparator. The second is a kick input that software toggles to prove it is alive. The third is an active-low inhibit input. The block drives a single active-low reset output. All timing is counted in ticks of a free-running reference clock.

One parameter, the watchdog period in ticks, sets every duration, and the ratios between them are fixed. The power-on release delay is 37/31 of the period. The reset pulse and the recharge phase both last one ninth of the period. Kicks are ignored during the first tenth of each period. Each derived count is rounded down to a whole tick.

Pulling inhibit low stops the watchdog, and reset then follows the supply flag alone. When inhibit is raised again, supervision restarts with a recharge phase.

Top module: `supv_reset_wdog`

## Requirements
- R1: While supplyOk is 0, resetN is 0 in the same cycle, whatever the watchdog is doing.
- R2: resetN rises only after supplyOk has been 1 for POR_TICKS = floor(WD_TICKS*37/31) consecutive clock edges. It stays 0 through the first POR_TICKS-1 of them. Any cycle with supplyOk at 0 restarts the count.
- R3: If no kick is accepted within WD_TICKS edges of a period start, resetN goes low for HOLD_TICKS = floor(WD_TICKS/9) edges. It then goes high, and a new period starts.
- R4: kickIn and inhibitN each pass through a two-flop synchronizer. The FSM acts on a change at the third rising edge after the input changes. A kick is only a 0-to-1 transition, so a level held high counts once.
- R5: A kick that reaches the FSM while the period count is below BLIND_TICKS = floor(WD_TICKS/10) is ignored. A kick that arrives at count BLIND_TICKS or later is accepted.
- R6: An accepted kick starts a recharge phase of HOLD_TICKS edges with resetN held high. A full new period of WD_TICKS edges follows.
- R7: While the synchronized inhibit is 0, the watchdog does not supervise and resetN equals supplyOk once the power-on delay is over.
- R8: When the synchronized inhibit returns to 1, a recharge phase of HOLD_TICKS edges runs first. A fresh period of WD_TICKS edges follows it.
- R9: The watchdog stays idle during the power-on delay. The first period starts on the edge that releases resetN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset of the logic |
| supplyOk | input | 1 | Synchronous supply-good flag from the comparator |
| kickIn | input | 1 | Watchdog kick from software, asynchronous |
| inhibitN | input | 1 | Active-low watchdog inhibit, asynchronous |
| resetN | output | 1 | Active-low system reset |

## Verification
The assertions assume that supplyOk is already synchronous to clk. They also assume that kickIn and inhibitN, although asynchronous, hold each level for at least three clock edges, so every change passes through the synchronizer. The bench drives every input on the falling clock edge. It holds kick and inhibit levels for at least three cycles, and it waits out a full reset pulse before the next kick edge. Because of this, each expected release or timeout edge can be counted exactly from the requirement ratios.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    PH_POR   = 3'd0,
    PH_WATCH = 3'd1,
    PH_RECHG = 3'd2,
    PH_HOLD  = 3'd3,
    PH_INHIB = 3'd4
  } phase_t;

  // control -> timer
  typedef struct packed {
    logic clear;
    logic advance;
  } tmr_strobe_t;

  // timer -> control
  typedef struct packed {
    logic porDone;
    logic periodDone;
    logic holdDone;
    logic blindOver;
  } tmr_flags_t;

  function automatic int porTicksOf(input int wd);
    return (wd * 37) / 31;
  endfunction

  function automatic int holdTicksOf(input int wd);
    return wd / 9;
  endfunction

  function automatic int blindTicksOf(input int wd);
    return wd / 10;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/supv_timer.sv
module supv_timer
  import supv_pkg::*;
#(
  parameter int WD_TICKS = 360
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmr_strobe_t          strobe,
  output tmr_flags_t           flags,
  output logic [$clog2(porTicksOf(WD_TICKS)+1)-1:0] count
);

  localparam int POR_TICKS   = porTicksOf(WD_TICKS);
  localparam int HOLD_TICKS  = holdTicksOf(WD_TICKS);
  localparam int BLIND_TICKS = blindTicksOf(WD_TICKS);
  localparam int CNT_W       = $clog2(POR_TICKS + 1);

  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_TICKS - 1);
  localparam logic [CNT_W-1:0] WD_LAST    = CNT_W'(WD_TICKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] BLIND_EDGE = CNT_W'(BLIND_TICKS);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tickCnt <= '0;
    else if (strobe.clear)   tickCnt <= '0;
    else if (strobe.advance) tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    flags.porDone    = (tickCnt == POR_LAST);
    flags.periodDone = (tickCnt == WD_LAST);
    flags.holdDone   = (tickCnt == HOLD_LAST);
    flags.blindOver  = (tickCnt >= BLIND_EDGE);
  end

  assign count = tickCnt;

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        kickLvl,
  input  logic        inhLvl,
  input  tmr_flags_t  flags,
  output tmr_strobe_t strobe,
  output phase_t      phase,
  output logic        resetN
);

  phase_t phaseNext;
  logic   kickPrev;
  logic   kickPulse;
  logic   inhActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= kickLvl;
  end

  assign kickPulse = kickLvl & ~kickPrev;
  assign inhActive = ~inhLvl;

  always_comb begin
    phaseNext      = phase;
    strobe.clear   = 1'b0;
    strobe.advance = 1'b1;
    if (!supplyOk) begin
      phaseNext      = PH_POR;
      strobe.clear   = 1'b1;
      strobe.advance = 1'b0;
    end else begin
      unique case (phase)
        PH_POR: begin
          if (flags.porDone) begin
            phaseNext    = inhActive ? PH_INHIB : PH_WATCH;
            strobe.clear = 1'b1;
          end
        end
        PH_WATCH: begin
          if (inhActive) begin
            phaseNext    = PH_INHIB;
            strobe.clear = 1'b1;
          end else if (kickPulse && flags.blindOver) begin
            phaseNext    = PH_RECHG;
            strobe.clear = 1'b1;
          end else if (flags.periodDone) begin
            phaseNext    = PH_HOLD;
            strobe.clear = 1'b1;
          end
        end
        PH_RECHG, PH_HOLD: begin
          if (inhActive) begin
            phaseNext    = PH_INHIB;
            strobe.clear = 1'b1;
          end else if (flags.holdDone) begin
            phaseNext    = PH_WATCH;
            strobe.clear = 1'b1;
          end
        end
        PH_INHIB: begin
          strobe.clear   = 1'b1;
          strobe.advance = 1'b0;
          if (!inhActive) phaseNext = PH_RECHG;
        end
        default: begin
          phaseNext    = PH_POR;
          strobe.clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_POR;
    else       phase <= phaseNext;
  end

  assign resetN = supplyOk & (phase != PH_POR) & (phase != PH_HOLD);

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog
  import supv_pkg::*;
#(
  parameter int WD_TICKS    = 31_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic kickIn,
  input  logic inhibitN,
  output logic resetN
);

  localparam int CNT_W = $clog2(porTicksOf(WD_TICKS) + 1);

  logic             kickLvl;
  logic             inhLvl;
  tmr_strobe_t      strobe;
  tmr_flags_t       flags;
  phase_t           phase;
  logic [CNT_W-1:0] tickCnt;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_kickSync (
    .clk(clk), .rstN(rstN), .din(kickIn), .dout(kickLvl)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_inhSync (
    .clk(clk), .rstN(rstN), .din(inhibitN), .dout(inhLvl)
  );

  supv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .kickLvl(kickLvl),
    .inhLvl(inhLvl), .flags(flags), .strobe(strobe), .phase(phase),
    .resetN(resetN)
  );

  supv_timer #(.WD_TICKS(WD_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(flags), .count(tickCnt)
  );

endmodule

// File: rtl/supv_reset_wdog_chk.sv
module supv_reset_wdog_chk
  import supv_pkg::*;
#(
  parameter int WD_TICKS = 360
) (
  input logic   clk,
  input logic   rstN,
  input logic   supplyOk,
  input logic   inhibitN,
  input logic   resetN,
  input phase_t phase,
  input logic [$clog2(porTicksOf(WD_TICKS)+1)-1:0] cnt
);

  localparam int POR_TICKS   = porTicksOf(WD_TICKS);
  localparam int HOLD_TICKS  = holdTicksOf(WD_TICKS);
  localparam int BLIND_TICKS = blindTicksOf(WD_TICKS);

  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  a_r1_supply_low_forces_reset: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> !resetN);

  a_r2_por_exit_count: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 3'd0 && $past(phase) == PH_POR && phase != PH_POR)
      |-> (int'($past(cnt)) == POR_TICKS - 1 && $past(supplyOk)));

  a_r3_hold_bounded: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_HOLD |-> int'(cnt) < HOLD_TICKS);

  a_r5_blind_no_recharge: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WATCH && int'(cnt) < BLIND_TICKS) |=> phase != PH_RECHG);

  a_r6_recharge_bounded: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_RECHG |-> int'(cnt) < HOLD_TICKS);

  a_r7_inhibit_follows_supply: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && !$past(inhibitN, 1) && !$past(inhibitN, 2) && !$past(inhibitN, 3)
      && supplyOk && phase != PH_POR) |-> resetN);

endmodule

bind supv_reset_wdog supv_reset_wdog_chk #(.WD_TICKS(WD_TICKS)) u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .inhibitN(inhibitN),
  .resetN(resetN), .phase(phase), .cnt(tickCnt)
);

// File: tb/supv_reset_wdog_tb.sv
module supv_reset_wdog_tb;

  localparam int WD    = 360;
  localparam int POR   = (WD * 37) / 31;
  localparam int HOLD  = WD / 9;
  localparam int BLIND = WD / 10;

  logic clk = 1'b0;
  logic rstN, supplyOk, kickIn, inhibitN;
  logic resetN;
  int   total = 0;
  int   bad   = 0;

  always #4 clk = ~clk;

  supv_reset_wdog #(.WD_TICKS(WD)) u_dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .kickIn(kickIn),
    .inhibitN(inhibitN), .resetN(resetN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    total++;
    if (resetN !== exp) begin
      bad++;
      $display("FAIL %s: resetN actual=%b expected=%b at %0t", req, resetN, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // R2 with a supply glitch part-way through the delay; R1 on the glitch
  task automatic t_por();
    supplyOk = 1'b1;
    step(POR / 2);
    supplyOk = 1'b0; #1;
    check("R1", 1'b0);
    step(2);
    supplyOk = 1'b1;
    step(POR - 1);
    check("R2", 1'b0);
    step(1);
    check("R2", 1'b1);
  endtask

  // R3 and R9: unkicked period from the release edge
  task automatic t_timeout();
    step(WD - 1);
    check("R9", 1'b1);
    step(1);
    check("R3", 1'b0);
    step(HOLD - 1);
    check("R3", 1'b0);
    step(1);
    check("R3", 1'b1);
  endtask

  // R5: kick reaching the FSM at count BLIND-1 is ignored
  task automatic t_kick_blind();
    step(BLIND - 3);
    kickIn = 1'b1;
    step(3);
    kickIn = 1'b0;
    step(WD - BLIND - 1);
    check("R5", 1'b1);
    step(1);
    check("R5", 1'b0);
    step(HOLD);
    check("R3", 1'b1);
  endtask

  // R5/R6/R4: kick at count BLIND accepted; level held high counts once
  task automatic t_kick_accept();
    step(BLIND - 2);
    kickIn = 1'b1;
    step(3);
    check("R6", 1'b1);
    step(HOLD);
    step(WD - 1);
    check("R6", 1'b1);
    step(1);
    check("R4", 1'b0);
    kickIn = 1'b0;
    step(HOLD);
    check("R3", 1'b1);
  endtask

  // R7, R8, R1 under inhibit
  task automatic t_inhibit();
    step(10);
    inhibitN = 1'b0;
    step(3);
    step(2 * WD);
    check("R7", 1'b1);
    supplyOk = 1'b0; #1;
    check("R1", 1'b0);
    step(2);
    supplyOk = 1'b1;
    step(POR - 1);
    check("R2", 1'b0);
    step(1);
    check("R7", 1'b1);
    step(WD + 5);
    check("R7", 1'b1);
    inhibitN = 1'b1;
    step(3 + HOLD + WD - 1);
    check("R8", 1'b1);
    step(1);
    check("R8", 1'b0);
    step(HOLD);
    check("R3", 1'b1);
  endtask

  // R1/R9: supply drop mid-period, watchdog restarts only at release
  task automatic t_supply_drop();
    step(50);
    supplyOk = 1'b0; #1;
    check("R1", 1'b0);
    step(1);
    check("R1", 1'b0);
    supplyOk = 1'b1;
    step(POR - 1);
    check("R9", 1'b0);
    step(1);
    check("R9", 1'b1);
    step(WD - 1);
    check("R9", 1'b1);
    step(1);
    check("R9", 1'b0);
    step(HOLD);
    check("R3", 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; supplyOk = 1'b0; kickIn = 1'b0; inhibitN = 1'b1;
    step(3);
    check("R1", 1'b0);
    rstN = 1'b1;
    step(2);
    check("R1", 1'b0);
    t_por();
    t_timeout();
    t_kick_blind();
    t_kick_accept();
    t_inhibit();
    t_supply_drop();
    summary();
    $finish;
  end

endmodule